// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a data cache placed between one processor port and a line-oriented backing-memory port. It holds 16 KB of data as 256 sets of two 32-byte lines each. It also holds a tag, a valid bit and a dirty bit for every line. Processor reads and writes are single 32-bit words with byte enables, and they use a valid/ready handshake. A hit completes in the cycle it is presented. A miss allocates a line for both reads and writes. If the chosen victim is dirty, it is written back as a whole line before the refill is requested. The refilled line then serves the access as a hit.

Only one replacement bit exists for the whole cache, and every set uses it. An invalid way is always filled first. When both ways of a set are valid, the way named by the shared bit is evicted and the bit flips. Addresses inside a fixed window are never cached: they pass to the memory port as single-word accesses. A one-cycle maintenance pulse starts a walk over every line. The walk writes back each valid dirty line, leaves every line invalid, and signals completion with a one-cycle pulse.

The controller is a single state machine. Its states are `ST_IDLE` (lookup and hit service), `ST_EVICT` (victim write-back), `ST_REFILL_REQ` and `ST_REFILL_WAIT` (line fetch), `ST_BYPASS_REQ` and `ST_BYPASS_WAIT` (uncached access), and `ST_SWEEP_SCAN`, `ST_SWEEP_WB` and `ST_SWEEP_DONE` (maintenance walk). Its transitions are:

- `ST_IDLE` to `ST_SWEEP_SCAN` when the maintenance pulse arrives.
- `ST_IDLE` to `ST_BYPASS_REQ` for a request inside the window.
- `ST_IDLE` to `ST_EVICT` on a miss whose victim is dirty.
- `ST_IDLE` to `ST_REFILL_REQ` on a miss whose victim is clean.
- `ST_EVICT` to `ST_REFILL_REQ` when the write-back is accepted.
- `ST_REFILL_REQ` to `ST_REFILL_WAIT` when the read is accepted.
- `ST_REFILL_WAIT` to `ST_IDLE` when the line arrives.
- `ST_BYPASS_REQ` to `ST_IDLE` when an uncached write is accepted.
- `ST_BYPASS_REQ` to `ST_BYPASS_WAIT` when an uncached read is accepted.
- `ST_BYPASS_WAIT` to `ST_IDLE` when the read data arrives.
- `ST_SWEEP_SCAN` to `ST_SWEEP_WB` when the current line is valid and dirty.
- `ST_SWEEP_SCAN` to `ST_SWEEP_DONE` after the last line.
- `ST_SWEEP_WB` back to `ST_SWEEP_SCAN` when the write-back is accepted, or to `ST_SWEEP_DONE` if that was the last line.
- `ST_SWEEP_DONE` to `ST_IDLE`.

Top module: `wb2way_cache`

## Requirements
- R1: The set index is address bits [12:5] and the byte offset within a line is bits [4:0]. Two addresses in the same 32-byte line share one cache line. Addresses 0x2000 apart map to the same set.
- R2: A cacheable access that hits raises `cpu_ready` in the same cycle `cpu_valid` is seen. A read hit returns the stored word. A write hit changes only the bytes whose `cpu_be` bit is 1 (bit n covers data bits 8n+7:8n) and marks the line dirty, with no memory traffic.
- R3: On a miss, way 0 is filled if it is invalid, otherwise way 1 if it is invalid. Either fill leaves the shared replacement bit unchanged.
- R4: On a miss to a set whose two ways are both valid, the victim is the way named by the single replacement bit shared by all sets, and the bit then flips.
- R5: A dirty victim is written back as one full-line write with all 32 strobes set, to its own line address, before the refill read is issued. A clean victim causes no memory write.
- R6: A write miss allocates the line, merges the write data under the byte enables into the refilled line, and leaves the line dirty.
- R7: Accesses with address bits [31:16] equal to 0x8000 never allocate and never hit. A write is issued as one memory write whose strobes cover only the enabled bytes of the addressed word. A read returns the addressed word from the memory line response.
- R8: A `maint_start` pulse accepted in idle visits set 0 to set 255, way 0 before way 1 in each set. It writes back exactly the valid dirty lines in that order, invalidates every line, then raises `maint_done` for one cycle. Afterwards every earlier address misses and reads the written-back data.
- R9: Reset clears all valid and dirty bits, sets the replacement bit to 0, and leaves `cpu_ready`, `mem_valid` and `maint_done` low.
- R10: `cpu_ready` is never high without `cpu_valid`. A request is held off (ready low) through every write-back and refill it needs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| maint_start | input | 1 | One-cycle pulse starting clean-and-invalidate of all lines |
| maint_done | output | 1 | One-cycle pulse at the end of the walk |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Line address, or the word address for uncached accesses |
| mem_wdata | output | 256 | Line write data |
| mem_wstrb | output | 32 | Byte strobes for the line write |
| mem_rvalid | input | 1 | Read response present |
| mem_rdata | input | 256 | Read response line |

## Verification
The bench uses the default parameters: 256 sets, 32-byte lines, 32-bit words, and the uncached window at 0x8000_0000 spanning 64 KB. This geometry lets addresses spaced 0x2000 apart collide in one set, so three-way conflicts bring out both first-invalid filling and shared-bit eviction. Alternating between sets 8 and 16 shows that a miss in one set changes the victim chosen in another. The full 512-line walk is short enough to run completely, including its ordering of write-backs across sets and ways.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int NWAYS = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EVICT,
        ST_REFILL_REQ,
        ST_REFILL_WAIT,
        ST_BYPASS_REQ,
        ST_BYPASS_WAIT,
        ST_SWEEP_SCAN,
        ST_SWEEP_WB,
        ST_SWEEP_DONE
    } wbc_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int TAG_W = 19,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx_i,
    input  logic                         fill_en_i,
    input  logic                         fill_way_i,
    input  logic [TAG_W-1:0]             fill_tag_i,
    input  logic                         inval_en_i,
    input  logic                         inval_way_i,
    input  logic                         dirty_en_i,
    input  logic                         dirty_way_i,
    output logic [NWAYS-1:0]             vld_o,
    output logic [NWAYS-1:0]             dty_o,
    output logic [NWAYS-1:0][TAG_W-1:0]  tag_o
);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  dty_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
                dty_q <= '0;
            end else if (fill_en_i && fill_way_i == 1'(w)) begin
                vld_q[idx_i] <= 1'b1;
                dty_q[idx_i] <= 1'b0;
            end else if (inval_en_i && inval_way_i == 1'(w)) begin
                vld_q[idx_i] <= 1'b0;
                dty_q[idx_i] <= 1'b0;
            end else if (dirty_en_i && dirty_way_i == 1'(w)) begin
                dty_q[idx_i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en_i && fill_way_i == 1'(w)) begin
                tag_q[idx_i] <= fill_tag_i;
            end
        end

        assign vld_o[w] = vld_q[idx_i];
        assign dty_o[w] = dty_q[idx_i];
        assign tag_o[w] = tag_q[idx_i];

        // a line can only be dirty while it is valid (R2, R6)
        assert_dirty_implies_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
            dty_o[w] |-> vld_o[w]);
    end

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
    import wbc_pkg::*;
#(
    parameter int SETS   = 256,
    parameter int LINE_W = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WORDS  = LINE_W / WORD_W,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BE_W   = WORD_W / 8
) (
    input  logic                          clk,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic                          line_we_i,
    input  logic                          line_way_i,
    input  logic [LINE_W-1:0]             line_i,
    input  logic                          word_we_i,
    input  logic                          word_way_i,
    input  logic [WSEL_W-1:0]             word_sel_i,
    input  logic [WORD_W-1:0]             word_i,
    input  logic [BE_W-1:0]               word_be_i,
    output logic [NWAYS-1:0][LINE_W-1:0]  line_o
);

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [LINE_W-1:0] arr_q [SETS];

        always_ff @(posedge clk) begin
            if (line_we_i && line_way_i == 1'(w)) begin
                arr_q[idx_i] <= line_i;
            end else if (word_we_i && word_way_i == 1'(w)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (word_be_i[b]) begin
                        arr_q[idx_i][word_sel_i*WORD_W + b*8 +: 8] <= word_i[b*8 +: 8];
                    end
                end
            end
        end

        assign line_o[w] = arr_q[idx_i];
    end

endmodule

// File: rtl/wbc_victim.sv
module wbc_victim
    import wbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [NWAYS-1:0] vld_i,
    output logic             way_o
);

    logic rr_q;

    always_comb begin
        if (!vld_i[0]) begin
            way_o = 1'b0;
        end else if (!vld_i[1]) begin
            way_o = 1'b1;
        end else begin
            way_o = rr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= 1'b0;
        end else if (alloc_i && (&vld_i)) begin
            rr_q <= ~rr_q;
        end
    end

    // the shared bit only moves on an allocation into a full set (R3, R4)
    assert_rr_moves_on_full_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_q != $past(rr_q)) |-> $past(alloc_i && (&vld_i)));

    // an allocation never picks a valid way while an invalid one exists (R3)
    assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !(&vld_i)) |-> !vld_i[way_o]);

endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
    import wbc_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          WORD_W     = 32,
    parameter int          LINE_BYTES = 32,
    parameter int          SETS       = 256,
    parameter logic [31:0] NC_BASE    = 32'h8000_0000,
    parameter int          NC_LOG2    = 16,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORDS  = LINE_W / WORD_W,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BE_W   = WORD_W / 8,
    localparam int BOFF_W = $clog2(BE_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_valid,
    output logic                  cpu_ready,
    input  logic                  cpu_write,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    input  logic [BE_W-1:0]       cpu_be,
    output logic [WORD_W-1:0]     cpu_rdata,
    input  logic                  maint_start,
    output logic                  maint_done,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic                  mem_write,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_wdata,
    output logic [LINE_BYTES-1:0] mem_wstrb,
    input  logic                  mem_rvalid,
    input  logic [LINE_W-1:0]     mem_rdata
);

    wbc_state_e st_q, st_d;

    logic [IDX_W-1:0] sw_idx_q;
    logic             sw_way_q;
    logic             vic_way_q;

    // address fields
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic [WSEL_W-1:0] cpu_wsel;
    logic              is_nc;

    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_wsel = cpu_addr[BOFF_W +: WSEL_W];
    assign is_nc    = (cpu_addr[ADDR_W-1:NC_LOG2] == NC_BASE[ADDR_W-1:NC_LOG2]);

    // array read port and lookup
    logic                        sweeping;
    logic [IDX_W-1:0]            look_idx;
    logic [NWAYS-1:0]            vld, dty, hit_w;
    logic [NWAYS-1:0][TAG_W-1:0] tag_arr;
    logic [NWAYS-1:0][LINE_W-1:0] line_arr;
    logic                        raw_hit, hit, hit_way;

    assign sweeping = (st_q == ST_SWEEP_SCAN) || (st_q == ST_SWEEP_WB);
    assign look_idx = sweeping ? sw_idx_q : cpu_idx;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_w[w] = vld[w] && (tag_arr[w] == cpu_tag);
    end

    assign raw_hit = |hit_w;
    assign hit     = raw_hit && !is_nc;
    assign hit_way = hit_w[1];

    // control strobes
    logic idle_go, alloc, vic_way, vic_dirty;
    logic fill_en, inval_en, dirty_en, needs_wb, sw_last;

    assign idle_go   = (st_q == ST_IDLE) && !maint_start && cpu_valid;
    assign alloc     = idle_go && !is_nc && !hit;
    assign vic_dirty = vld[vic_way] && dty[vic_way];
    assign fill_en   = (st_q == ST_REFILL_WAIT) && mem_rvalid;
    assign dirty_en  = idle_go && hit && cpu_write;
    assign needs_wb  = vld[sw_way_q] && dty[sw_way_q];
    assign sw_last   = sw_way_q && (sw_idx_q == IDX_W'(SETS - 1));
    assign inval_en  = ((st_q == ST_SWEEP_SCAN) && !needs_wb) ||
                       ((st_q == ST_SWEEP_WB) && mem_ready);

    wbc_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_i       (look_idx),
        .fill_en_i   (fill_en),
        .fill_way_i  (vic_way_q),
        .fill_tag_i  (cpu_tag),
        .inval_en_i  (inval_en),
        .inval_way_i (sw_way_q),
        .dirty_en_i  (dirty_en),
        .dirty_way_i (hit_way),
        .vld_o       (vld),
        .dty_o       (dty),
        .tag_o       (tag_arr)
    );

    wbc_data_store #(
        .SETS   (SETS),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) i_data (
        .clk        (clk),
        .idx_i      (look_idx),
        .line_we_i  (fill_en),
        .line_way_i (vic_way_q),
        .line_i     (mem_rdata),
        .word_we_i  (dirty_en),
        .word_way_i (hit_way),
        .word_sel_i (cpu_wsel),
        .word_i     (cpu_wdata),
        .word_be_i  (cpu_be),
        .line_o     (line_arr)
    );

    wbc_victim i_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_i (alloc),
        .vld_i   (vld),
        .way_o   (vic_way)
    );

    // sweep position and victim way
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_idx_q  <= '0;
            sw_way_q  <= 1'b0;
            vic_way_q <= 1'b0;
        end else begin
            if ((st_q == ST_IDLE) && maint_start) begin
                sw_idx_q <= '0;
                sw_way_q <= 1'b0;
            end else if (inval_en) begin
                sw_way_q <= ~sw_way_q;
                if (sw_way_q) begin
                    sw_idx_q <= sw_idx_q + 1'b1;
                end
            end
            if (alloc) begin
                vic_way_q <= vic_way;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (maint_start) begin
                    st_d = ST_SWEEP_SCAN;
                end else if (cpu_valid && is_nc) begin
                    st_d = ST_BYPASS_REQ;
                end else if (cpu_valid && !hit) begin
                    st_d = vic_dirty ? ST_EVICT : ST_REFILL_REQ;
                end
            end
            ST_EVICT:       if (mem_ready)  st_d = ST_REFILL_REQ;
            ST_REFILL_REQ:  if (mem_ready)  st_d = ST_REFILL_WAIT;
            ST_REFILL_WAIT: if (mem_rvalid) st_d = ST_IDLE;
            ST_BYPASS_REQ:  if (mem_ready)  st_d = cpu_write ? ST_IDLE : ST_BYPASS_WAIT;
            ST_BYPASS_WAIT: if (mem_rvalid) st_d = ST_IDLE;
            ST_SWEEP_SCAN: begin
                if (needs_wb) begin
                    st_d = ST_SWEEP_WB;
                end else if (sw_last) begin
                    st_d = ST_SWEEP_DONE;
                end
            end
            ST_SWEEP_WB: begin
                if (mem_ready) begin
                    st_d = sw_last ? ST_SWEEP_DONE : ST_SWEEP_SCAN;
                end
            end
            ST_SWEEP_DONE:  st_d = ST_IDLE;
            default:        st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready  = 1'b0;
        cpu_rdata  = line_arr[hit_way][cpu_wsel*WORD_W +: WORD_W];
        maint_done = 1'b0;
        mem_valid  = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
        mem_wdata  = line_arr[vic_way_q];
        mem_wstrb  = '1;
        unique case (st_q)
            ST_IDLE: begin
                cpu_ready = idle_go && hit;
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_arr[vic_way_q], cpu_idx, OFF_W'(0)};
            end
            ST_REFILL_REQ: begin
                mem_valid = 1'b1;
            end
            ST_BYPASS_REQ: begin
                mem_valid = 1'b1;
                mem_write = cpu_write;
                mem_addr  = cpu_addr;
                mem_wdata = {WORDS{cpu_wdata}};
                mem_wstrb = cpu_write ? (LINE_BYTES'(cpu_be) << (cpu_wsel * BE_W)) : '0;
                cpu_ready = cpu_write && mem_ready;
            end
            ST_BYPASS_WAIT: begin
                cpu_ready = mem_rvalid;
                cpu_rdata = mem_rdata[cpu_wsel*WORD_W +: WORD_W];
            end
            ST_SWEEP_WB: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_arr[sw_way_q], sw_idx_q, OFF_W'(0)};
                mem_wdata = line_arr[sw_way_q];
            end
            ST_SWEEP_DONE: begin
                maint_done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // completion only answers a live request (R10)
    assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    // cached line traffic always carries a full strobe set (R5)
    assert_full_line_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && (st_q != ST_BYPASS_REQ)) |-> (&mem_wstrb));

    // an accepted eviction is followed by the refill read of the requested line (R5)
    assert_evict_then_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_EVICT) && mem_ready) |=>
            (mem_valid && !mem_write && mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

    // window addresses are never resident in the arrays (R7)
    assert_nc_never_resident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && is_nc && !sweeping) |-> !raw_hit);

    // the completion marker lasts one cycle (R8)
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        maint_done |=> !maint_done);

    // no processor completion while lines are being walked (R8, R10)
    assert_quiet_during_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> !cpu_ready);

endmodule

// File: tb/test_wb2way_cache.sv
module test_wb2way_cache;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        fast;   // expected to complete in the first cycle (hit)
        logic [1:0]  nwb;    // expected number of memory writes
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0000_0100, 32'h0,         4'h0, 1'b0, 2'd0}, // 0  R3 miss fills way0
        '{1'b0, 32'h0000_0104, 32'h0,         4'h0, 1'b1, 2'd0}, // 1  R1 same line hits
        '{1'b1, 32'h0000_0108, 32'h1122_3344, 4'hF, 1'b1, 2'd0}, // 2  R2 write hit
        '{1'b0, 32'h0000_0108, 32'h0,         4'h0, 1'b1, 2'd0}, // 3  R2 read back
        '{1'b0, 32'h0000_2100, 32'h0,         4'h0, 1'b0, 2'd0}, // 4  R3 fills way1
        '{1'b1, 32'h0000_4100, 32'hAAAA_BBBB, 4'h3, 1'b0, 2'd1}, // 5  R4 R5 R6 dirty way0 evicted
        '{1'b0, 32'h0000_4100, 32'h0,         4'h0, 1'b1, 2'd0}, // 6  R6 merged hit
        '{1'b0, 32'h0000_0108, 32'h0,         4'h0, 1'b0, 2'd0}, // 7  R4 way1 clean victim
        '{1'b0, 32'h0000_2100, 32'h0,         4'h0, 1'b0, 2'd1}, // 8  R5 dirty 0x4100 out
        '{1'b0, 32'h0000_4100, 32'h0,         4'h0, 1'b0, 2'd0}, // 9  R5 data survived
        '{1'b0, 32'h0000_0200, 32'h0,         4'h0, 1'b0, 2'd0}, // 10 R3 other set way0
        '{1'b0, 32'h0000_2200, 32'h0,         4'h0, 1'b0, 2'd0}, // 11 R3 way1
        '{1'b0, 32'h0000_4200, 32'h0,         4'h0, 1'b0, 2'd0}, // 12 R4 bit was 0
        '{1'b0, 32'h0000_0100, 32'h0,         4'h0, 1'b0, 2'd0}, // 13 R4 shared bit now 1
        '{1'b0, 32'h0000_2100, 32'h0,         4'h0, 1'b1, 2'd0}, // 14 R4 way0 kept
        '{1'b0, 32'h0000_4100, 32'h0,         4'h0, 1'b0, 2'd0}, // 15 R4 way1 was evicted
        '{1'b0, 32'h0000_0100, 32'h0,         4'h0, 1'b1, 2'd0}, // 16 R4 still resident
        '{1'b1, 32'h8000_0014, 32'hCAFE_F00D, 4'hF, 1'b0, 2'd1}, // 17 R7 uncached write
        '{1'b0, 32'h8000_0014, 32'h0,         4'h0, 1'b0, 2'd0}, // 18 R7 uncached read
        '{1'b0, 32'h8000_0014, 32'h0,         4'h0, 1'b0, 2'd0}, // 19 R7 no allocation
        '{1'b1, 32'h0000_0104, 32'h00EE_0000, 4'h4, 1'b1, 2'd0}, // 20 R2 single byte
        '{1'b0, 32'h0000_0104, 32'h0,         4'h0, 1'b1, 2'd0}  // 21 R2 merged byte
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0;
    logic         cpu_ready;
    logic         cpu_write = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic [31:0]  cpu_rdata;
    logic         maint_start = 1'b0;
    logic         maint_done;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic         mem_write;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wdata;
    logic [31:0]  mem_wstrb;
    logic         mem_rvalid = 1'b0;
    logic [255:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb2way_cache i_wb2way_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_valid   (cpu_valid),
        .cpu_ready   (cpu_ready),
        .cpu_write   (cpu_write),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_be      (cpu_be),
        .cpu_rdata   (cpu_rdata),
        .maint_start (maint_start),
        .maint_done  (maint_done),
        .mem_valid   (mem_valid),
        .mem_ready   (mem_ready),
        .mem_write   (mem_write),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_wstrb   (mem_wstrb),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata)
    );

    // ---------------- backing memory model ----------------
    logic [31:0] mem_words [logic [31:0]];
    logic [31:0] gold      [logic [31:0]];
    logic [31:0] wr_log [16];
    int          wr_cnt = 0;
    logic        rd_busy = 1'b0;
    int          rd_wait = 0;
    logic [31:0] rd_addr = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] wa);
        return mem_words.exists(wa) ? mem_words[wa] : pat(wa);
    endfunction

    function automatic logic [255:0] mem_line(input logic [31:0] a);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) begin
            l[k*32 +: 32] = mem_word({a[31:5], 5'b0} + 32'(k*4));
        end
        return l;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_busy) begin
            if (rd_wait == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_line(rd_addr);
                rd_busy    <= 1'b0;
            end else begin
                rd_wait <= rd_wait - 1;
            end
        end
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                for (int k = 0; k < 8; k++) begin
                    logic [31:0] wa;
                    logic [31:0] cur;
                    wa  = {mem_addr[31:5], 5'b0} + 32'(k*4);
                    cur = mem_word(wa);
                    for (int b = 0; b < 4; b++) begin
                        if (mem_wstrb[k*4+b]) cur[b*8 +: 8] = mem_wdata[k*32 + b*8 +: 8];
                    end
                    if (|mem_wstrb[k*4 +: 4]) mem_words[wa] = cur;
                end
                wr_log[wr_cnt % 16] = {mem_addr[31:5], 5'b0};
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_busy <= 1'b1;
                rd_wait <= 1;
                rd_addr <= mem_addr;
            end
        end
    end

    // ---------------- checking helpers ----------------
    function automatic logic [31:0] gold_rd(input logic [31:0] a);
        logic [31:0] wa;
        wa = {a[31:2], 2'b0};
        return gold.exists(wa) ? gold[wa] : pat(wa);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_access(input vec_t v, input string req);
        int          polls;
        int          wb0;
        logic [31:0] got;
        @(negedge clk);
        wb0       = wr_cnt;
        cpu_valid = 1'b1;
        cpu_write = v.wr;
        cpu_addr  = v.addr;
        cpu_wdata = v.wdata;
        cpu_be    = v.be;
        #1;
        polls = 0;
        while (!cpu_ready && polls < 200) begin
            @(negedge clk);
            #1;
            polls++;
        end
        got = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0;
        check(polls < 200, req, "completion", 32'(polls), 32'd0);
        check((polls == 0) == v.fast, req, "hit timing", 32'(polls == 0), 32'(v.fast));
        check(wr_cnt - wb0 == int'(v.nwb), req, "memory writes", 32'(wr_cnt - wb0), 32'(v.nwb));
        if (v.wr) begin
            logic [31:0] cur;
            cur = gold_rd(v.addr);
            for (int b = 0; b < 4; b++) begin
                if (v.be[b]) cur[b*8 +: 8] = v.wdata[b*8 +: 8];
            end
            gold[{v.addr[31:2], 2'b0}] = cur;
        end else begin
            check(got == gold_rd(v.addr), req, "read data", got, gold_rd(v.addr));
        end
    endtask

    task automatic acc(input logic wr, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic fast, input logic [1:0] nwb,
                       input string req);
        vec_t v;
        v = '{wr, a, d, be, fast, nwb};
        do_access(v, req);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R9 reset state at the ports
        check(!cpu_ready, "R9", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
        check(!mem_valid, "R9", "mem_valid after reset", 32'(mem_valid), 32'd0);
        check(!maint_done, "R9", "maint_done after reset", 32'(maint_done), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_access(VECS[i], $sformatf("vec%0d", i));
        end

        // R8 make three lines dirty, then walk
        acc(1'b1, 32'h0000_4104, 32'h7777_8888, 4'hF, 1'b1, 2'd0, "R2");
        acc(1'b1, 32'h0000_2200, 32'h0102_0304, 4'hF, 1'b1, 2'd0, "R2");
        begin
            int wb0;
            int polls;
            wb0 = wr_cnt;
            @(negedge clk);
            maint_start = 1'b1;
            @(negedge clk);
            maint_start = 1'b0;
            #1;
            polls = 0;
            while (!maint_done && polls < 2000) begin
                @(negedge clk);
                #1;
                polls++;
            end
            check(maint_done, "R8", "walk completes", 32'(maint_done), 32'd1);
            check(wr_cnt - wb0 == 3, "R8", "dirty write-backs", 32'(wr_cnt - wb0), 32'd3);
            check(wr_log[wb0 % 16] == 32'h0000_4100, "R8", "first write-back",
                  wr_log[wb0 % 16], 32'h0000_4100);
            check(wr_log[(wb0 + 1) % 16] == 32'h0000_0100, "R8", "second write-back",
                  wr_log[(wb0 + 1) % 16], 32'h0000_0100);
            check(wr_log[(wb0 + 2) % 16] == 32'h0000_2200, "R8", "third write-back",
                  wr_log[(wb0 + 2) % 16], 32'h0000_2200);
            @(negedge clk);
            #1;
            check(!maint_done, "R8", "done is one cycle", 32'(maint_done), 32'd0);
        end
        // R8 everything now misses with written-back data
        acc(1'b0, 32'h0000_4104, 32'h0, 4'h0, 1'b0, 2'd0, "R8");
        acc(1'b0, 32'h0000_0104, 32'h0, 4'h0, 1'b0, 2'd0, "R8");
        acc(1'b0, 32'h0000_2200, 32'h0, 4'h0, 1'b0, 2'd0, "R8");

        // R9 reset mid-run clears the lines and returns the shared bit to 0
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        acc(1'b0, 32'h0000_2100, 32'h0, 4'h0, 1'b0, 2'd0, "R9");
        acc(1'b0, 32'h0000_4100, 32'h0, 4'h0, 1'b0, 2'd0, "R9");
        acc(1'b0, 32'h0000_0100, 32'h0, 4'h0, 1'b0, 2'd0, "R9");
        acc(1'b0, 32'h0000_4100, 32'h0, 4'h0, 1'b1, 2'd0, "R9");
        acc(1'b0, 32'h0000_2100, 32'h0, 4'h0, 1'b0, 2'd0, "R9");
        // R10 ready never seen without valid
        @(negedge clk);
        #1;
        check(!cpu_ready, "R10", "idle ready", 32'(cpu_ready), 32'd0);

        finish_run();
    end

endmodule